// File: doc/BRIEF.md
# AVI Infoframe Send Scheduler

This block decides when an HDMI AVI infoframe is offered to a downstream packetizer during vertical blanking. Software programs four 32-bit staging words and a small control register. The block keeps a second, live copy of the payload, and that copy is the one presented on the output. Software asks for the staging words to be flushed into the live copy. The flush is deferred to the next frame boundary, so a packet never carries a mix of old and new words.

A level blanking input paces the block. Each rising edge of that input marks a frame boundary. While sending is enabled, the block raises a one-cycle request at chosen boundaries. The request comes either every frame or every second frame. The live payload is held steady beside the request. Checksum generation, TMDS coding and data-island insertion belong to later stages.

Top module: `avi_pkt_sched`

## Requirements
- R1: After reset, sending is disabled and the cadence is every frame. No update is pending, the control readback is 0, and both the staging and live payloads are zero.
- R2: While control bit 0 (enable) is 0, `pkt_req` never asserts.
- R3: With enable set and control bit 1 at 0, every frame boundary produces a request.
- R4: With enable set and control bit 1 at 1, requests alternate between frames. The first boundary after enable goes from 0 to 1 sends, the next one skips, and so on.
- R5: A frame boundary is a clock edge at which `vblank` is sampled 1 after being sampled 0. The request is high for exactly the one cycle that follows that edge.
- R6: Writing 1 to control bit 2 (update) marks a flush as pending. At the next frame boundary the four staging words are copied to `pkt_payload`, and the copy is already visible in the cycle that carries that boundary's request.
- R7: The update bit reads back as 1 while the flush is pending. Hardware clears it at the boundary that performs the copy. Writing 0 to it has no effect.
- R8: A write to a staging word never changes `pkt_payload` by itself. If several writes reach the same word before the flush, the last one is the value that gets copied.
- R9: Address 0 is the control register. Addresses 1 to 4 hold staging words 0 to 3, and word k occupies `pkt_payload[32k+31:32k]`. `rd_ctrl` returns {update, cadence, enable} in bits 2 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| vblank | input | 1 | Level blanking indicator from the timing generator |
| rd_ctrl | output | 3 | Control readback {update, cadence, enable} |
| pkt_req | output | 1 | One-cycle packet request strobe |
| pkt_payload | output | 128 | Live infoframe payload |

## Verification
A wrong cadence toggle shows up at the first or second frame boundary after enabling, either as a missing request or as an extra one. A stale or early live copy shows up on `pkt_payload` within one cycle, either right after a staging write or at the flush boundary. A stuck update flag is seen on `rd_ctrl` one cycle after the boundary that should have cleared it.

// File: rtl/avi_pkg.sv
package avi_pkg;
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_FREQ_BIT = 1;
   localparam int CTRL_UPD_BIT  = 2;

   typedef struct packed {
      logic upd;
      logic every_other;
      logic en;
   } avi_ctrl_t;
endpackage

// File: rtl/avi_regs.sv
module avi_regs
   import avi_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int ADDR_W = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      frame_start,
   output avi_ctrl_t                 ctrl,
   output logic                      en_rise,
   output logic                      flush,
   output logic [WORDS*DATA_W-1:0]   staging
);
   localparam int NREGS = WORDS + 1;

   initial begin
      assert (NREGS <= (1 << ADDR_W)) else $error("address space too small");
      assert (DATA_W >= 3) else $error("data width too small for control");
   end

   logic wr_ctrl, upd_set;
   assign wr_ctrl = wr_en && (wr_addr == '0);
   assign upd_set = wr_ctrl && wr_data[CTRL_UPD_BIT];
   assign en_rise = wr_ctrl && wr_data[CTRL_EN_BIT] && !ctrl.en;
   assign flush   = frame_start && ctrl.upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl.en          <= wr_data[CTRL_EN_BIT];
            ctrl.every_other <= wr_data[CTRL_FREQ_BIT];
         end
         if (upd_set)
            ctrl.upd <= 1'b1;
         else if (frame_start)
            ctrl.upd <= 1'b0;
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            staging[w*DATA_W +: DATA_W] <= '0;
         else if (wr_en && (wr_addr == ADDR_W'(w + 1)))
            staging[w*DATA_W +: DATA_W] <= wr_data;
      end
   end

   // R7
   upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && ctrl.upd && !upd_set) |=> !ctrl.upd);
endmodule

// File: rtl/avi_cadence.sv
module avi_cadence (
   input  logic clk,
   input  logic rst_n,
   input  logic vblank,
   input  logic en,
   input  logic every_other,
   input  logic en_rise,
   output logic frame_start,
   output logic pkt_req
);
   logic vb_q, tog;

   assign frame_start = vblank && !vb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vb_q    <= 1'b0;
         tog     <= 1'b0;
         pkt_req <= 1'b0;
      end else begin
         vb_q    <= vblank;
         pkt_req <= frame_start && en && (!every_other || !tog);
         if (en_rise)
            tog <= 1'b0;
         else if (frame_start && en)
            tog <= !tog;
      end
   end

   // R2
   req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_req |-> $past(en));
   // R5
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_req |=> !pkt_req);
endmodule

// File: rtl/avi_live.sv
module avi_live #(
   parameter int WIDTH = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] staging,
   output logic [WIDTH-1:0] live
);
   initial assert (WIDTH > 0) else $error("bad payload width");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         live <= '0;
      else if (load)
         live <= staging;
   end

   // R8
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(live));
endmodule

// File: rtl/avi_pkt_sched.sv
module avi_pkt_sched
   import avi_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int ADDR_W = 3,
   localparam int PAY_W = DATA_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              vblank,
   output logic [2:0]        rd_ctrl,
   output logic              pkt_req,
   output logic [PAY_W-1:0]  pkt_payload
);
   avi_ctrl_t        ctrl;
   logic             en_rise, flush, frame_start;
   logic [PAY_W-1:0] staging;

   avi_regs #(.DATA_W(DATA_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
      .wr_data(reg_wdata), .frame_start(frame_start), .ctrl(ctrl),
      .en_rise(en_rise), .flush(flush), .staging(staging));

   avi_cadence u_cad (
      .clk(clk), .rst_n(rst_n), .vblank(vblank), .en(ctrl.en),
      .every_other(ctrl.every_other), .en_rise(en_rise),
      .frame_start(frame_start), .pkt_req(pkt_req));

   avi_live #(.WIDTH(PAY_W)) u_live (
      .clk(clk), .rst_n(rst_n), .load(flush), .staging(staging),
      .live(pkt_payload));

   assign rd_ctrl = ctrl;
endmodule

// File: tb/test_avi_pkt_sched.sv
module test_avi_pkt_sched;
   logic         clk = 0, rst_n = 0, reg_wr = 0, vblank = 0;
   logic [2:0]   reg_addr = 0;
   logic [31:0]  reg_wdata = 0;
   logic [2:0]   rd_ctrl;
   logic         pkt_req;
   logic [127:0] pkt_payload;

   int checks = 0, errors = 0;
   logic         m_en = 0, m_freq = 0, m_tog = 0, m_pend = 0;
   logic [127:0] m_stage = '0, m_live = '0;

   always #4 clk = ~clk;

   avi_pkt_sched i_avi_pkt_sched (.*);

   task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_ctrl();
      return {m_pend, m_freq, m_en};
   endfunction

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
      if (a == 0) begin
         if (d[0] && !m_en) m_tog = 0;
         m_en = d[0]; m_freq = d[1];
         if (d[2]) m_pend = 1;
      end else begin
         m_stage[(a-1)*32 +: 32] = d;
      end
      chk(rd_ctrl == exp_ctrl(), "R9 ctrl readback", 128'(rd_ctrl), 128'(exp_ctrl()));
      chk(pkt_payload == m_live, "R8 payload unchanged by write", pkt_payload, m_live);
   endtask

   task automatic frame(input int act_len, input int blk_len);
      logic exp_req;
      for (int i = 0; i < act_len; i++) begin
         vblank = 0;
         @(negedge clk);
         chk(pkt_req == 0, "R5 no req in active", 128'(pkt_req), 0);
      end
      vblank = 1;
      @(negedge clk);
      exp_req = m_en && (!m_freq || !m_tog);
      if (m_en) m_tog = !m_tog;
      if (m_pend) begin m_live = m_stage; m_pend = 0; end
      chk(pkt_req == exp_req, "R2/R3/R4 req at boundary", 128'(pkt_req), 128'(exp_req));
      chk(pkt_payload == m_live, "R6 payload at boundary", pkt_payload, m_live);
      chk(rd_ctrl == exp_ctrl(), "R7 update cleared", 128'(rd_ctrl), 128'(exp_ctrl()));
      for (int i = 1; i < blk_len; i++) begin
         @(negedge clk);
         chk(pkt_req == 0, "R5 single pulse", 128'(pkt_req), 0);
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      chk(rd_ctrl == 0, "R1 ctrl reset", 128'(rd_ctrl), 0);
      chk(pkt_payload == 0, "R1 payload reset", pkt_payload, 0);
      // R2: disabled, staged data and flush, no requests
      wr(3'd1, 32'hA1A1_0001);
      wr(3'd4, 32'hD4D4_0004);
      repeat (2) frame(3, 3);
      // R8: latest staging wins, R6/R7 flush
      wr(3'd2, 32'h1111_2222);
      wr(3'd0, 32'h4);
      wr(3'd2, 32'h3333_4444);
      chk(rd_ctrl[2] == 1, "R7 pending readback", 128'(rd_ctrl), 128'(4));
      wr(3'd0, 32'h0);
      chk(rd_ctrl[2] == 1, "R7 write 0 ignored", 128'(rd_ctrl), 128'(4));
      frame(2, 2);
      // R9 field position of word 1
      chk(pkt_payload[63:32] == 32'h3333_4444, "R9 word1 position", 128'(pkt_payload[63:32]), 128'h3333_4444);
      // R3 every frame
      wr(3'd0, 32'h1);
      repeat (3) frame(4, 2);
      // R4 every other, re-armed by enable
      wr(3'd0, 32'h0);
      wr(3'd0, 32'h3);
      repeat (4) frame(2, 3);
      wr(3'd0, 32'h7);
      wr(3'd3, 32'hCAFE_F00D);
      frame(3, 2);
      // random mix
      for (int n = 0; n < 150; n++) begin
         case ($urandom_range(0, 3))
            0: wr(3'd0, 32'($urandom_range(0, 7)));
            1, 2: wr(3'($urandom_range(1, 4)), $urandom);
            default: frame($urandom_range(2, 9), $urandom_range(2, 5));
         endcase
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule